// File: doc/BRIEF.md
# Two-Way Interleaved Multiply Stage

This block stands in for a single pipeline stage whose combinational function is too slow to settle within one clock period. Two identical instances of that function sit side by side. Each has its own operand register. A phase flip-flop steers arriving operands to the two copies in turn. The first cycle after reset, and every second cycle after it, feeds the first copy. The cycles in between feed the second copy. Each copy therefore keeps its operands for two full periods. A function that needs twice the clock period still settles before its result is used.

The same phase bit drives the output multiplexer. In any cycle the multiplexer shows the copy that was loaded two cycles earlier. That copy has had its full two periods and is read just before it takes new operands. Seen from outside, the pair behaves like one fully pipelined stage that has been cut into two sub-stages. It accepts one item per cycle and returns each result two cycles later, in arrival order. The slow function here is an unsigned multiply of two `W`-bit operands into a `2W`-bit product. A valid flag travels beside the data, so idle cycles leave the block in the same positions they entered. There is no stall or back-pressure.

Top module: `interleave_stage`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `out_valid` is 0.
- R2: An item presented with `in_valid` high in cycle c appears with `out_valid` high in cycle c+2, with `out_data` equal to `in_a * in_b`.
- R3: A copy's operand register loads only in its own phase: copy 1 in phase 0 and copy 2 in phase 1. A copy's result does not change across a cycle spent in the other phase.
- R4: The phase bit resets to 0, which selects copy 1, and inverts on every clock edge whether or not an item is present.
- R5: After a copy is loaded, its result stays stable through the following cycle, which gives it a two-cycle settling window.
- R6: `out_valid` in cycle c+2 equals `in_valid` in cycle c, so idle cycles are kept in place and in order.
- R7: When `out_valid` is 0, `out_data` is 0.
- R8: With `in_valid` held high, one result leaves per cycle, with no gaps.
- R9: Results leave in the same order the items arrived.
- R10: The product is the full `2W`-bit unsigned value, including the case where both operands are at their maximum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An item is present this cycle |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| out_valid | output | 1 | A result is present this cycle |
| out_data | output | 2W | Product, or 0 when no result is present |

## Verification
The checks assume that `in_a`, `in_b` and `in_valid` are free of X and change only between clock edges. They also assume that any two-cycle look-back starts no earlier than the reset release. The bench drives all inputs on the falling edge and keeps `in_valid` low throughout reset, so the first two cycles after release can only compare against idle inputs. The stimulus covers every operand pair at full rate. It also uses sparse valid patterns, including one that lands every item on the same copy, and a reset asserted while items are in flight.

// File: rtl/il_pkg.sv
package il_pkg;
    // Which copy takes operands this cycle.
    typedef enum logic {
        PH_C1 = 1'b0,
        PH_C2 = 1'b1
    } phase_e;

    localparam int NUM_COPIES = 2;
endpackage

// File: rtl/il_phase_ctrl.sv
module il_phase_ctrl
    import il_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output phase_e                phase,
    output logic [NUM_COPIES-1:0] load_en,
    output logic                  out_valid
);
    localparam int DEPTH = 2;

    typedef struct packed {
        phase_e           ph;
        logic [DEPTH-1:0] vsh;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ph  = (st_q.ph == PH_C1) ? PH_C2 : PH_C1;
        st_d.vsh = {st_q.vsh[DEPTH-2:0], in_valid};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_C1, vsh: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase      = st_q.ph;
    assign load_en[0] = in_valid && (st_q.ph == PH_C1);
    assign load_en[1] = in_valid && (st_q.ph == PH_C2);
    assign out_valid  = st_q.vsh[DEPTH-1];
endmodule

// File: rtl/il_copy.sv
module il_copy #(
    parameter int W = 8,
    localparam int PW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [PW-1:0] res
);
    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
    } opnd_t;

    opnd_t op_d, op_q;

    always_comb begin
        op_d = op_q;
        if (ld) begin
            op_d.a = a;
            op_d.b = b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= '0;
        end else begin
            op_q <= op_d;
        end
    end

    // Slow function: allowed two clock periods to settle.
    assign res = PW'(op_q.a) * PW'(op_q.b);
endmodule

// File: rtl/interleave_stage.sv
module interleave_stage
    import il_pkg::*;
#(
    parameter int W = 8,
    localparam int PW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  in_a,
    input  logic [W-1:0]  in_b,
    output logic          out_valid,
    output logic [PW-1:0] out_data
);
    phase_e                          phase;
    logic [NUM_COPIES-1:0]           load_en;
    logic [NUM_COPIES-1:0][PW-1:0]   cp_res;
    logic                            sel;

    il_phase_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .phase     (phase),
        .load_en   (load_en),
        .out_valid (out_valid)
    );

    for (genvar g = 0; g < NUM_COPIES; g++) begin : gen_copy
        il_copy #(.W(W)) u_copy (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (load_en[g]),
            .a     (in_a),
            .b     (in_b),
            .res   (cp_res[g])
        );
    end

    // The copy loaded two cycles ago shares the current phase value.
    assign sel      = phase;
    assign out_data = out_valid ? cp_res[sel] : '0;
endmodule

// File: rtl/il_check.sv
module il_check
    import il_pkg::*;
#(
    parameter int W = 8,
    localparam int PW = 2 * W
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic [W-1:0]                  in_a,
    input logic [W-1:0]                  in_b,
    input logic                          out_valid,
    input logic [PW-1:0]                 out_data,
    input phase_e                        phase,
    input logic [NUM_COPIES-1:0]         load_en,
    input logic [NUM_COPIES-1:0][PW-1:0] cp_res
);
    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd2) begin
            age <= age + 2'd1;
        end
    end

    AST_FIRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd0) |-> !out_valid); // R1
    AST_RESULT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && out_valid) |-> out_data == PW'($past(in_a, 2)) * PW'($past(in_b, 2))); // R2
    AST_C1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_C2) |=> $stable(cp_res[0])); // R3
    AST_C2_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_C1) |=> $stable(cp_res[1])); // R3
    AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_en)); // R3
    AST_PHASE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd0) |-> phase == PH_C1); // R4
    AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0) |-> phase != $past(phase)); // R4
    AST_C1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        load_en[0] |=> ##1 $stable(cp_res[0])); // R5
    AST_C2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        load_en[1] |=> ##1 $stable(cp_res[1])); // R5
    AST_VALID_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> out_valid == $past(in_valid, 2)); // R6
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_data == '0); // R7
endmodule

bind interleave_stage il_check #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_data  (out_data),
    .phase     (phase),
    .load_en   (load_en),
    .cp_res    (cp_res)
);

// File: tb/sim_interleave_stage.sv
`timescale 1ns/1ps
module sim_interleave_stage;
    localparam int W  = 4;
    localparam int PW = 2 * W;
    localparam int N  = 1 << W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_a = '0;
    logic [W-1:0]  in_b = '0;
    logic          out_valid;
    logic [PW-1:0] out_data;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int nvalid = 0;
    bit vh0 = 1'b0;
    bit vh1 = 1'b0;
    logic [PW-1:0] q_data[$];
    int q_tag[$];

    always #2.5 clk = ~clk;

    interleave_stage #(.W(W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Called at a falling edge: checks the outputs for the item sent two steps ago,
    // then drives the next item.
    task automatic step(bit v, logic [W-1:0] a, logic [W-1:0] b, string req);
        logic [PW-1:0] exp_d;
        int tag;
        chk(out_valid == vh1, "R6", "out_valid", out_valid, vh1);
        if (out_valid) nvalid++;
        if (vh1 && out_valid && q_data.size() > 0) begin
            exp_d = q_data.pop_front();
            tag   = q_tag.pop_front();
            chk(out_data == exp_d, req, "product", out_data, exp_d);
            chk(tag == cyc - 2, "R9", "order tag", tag, cyc - 2);
        end else if (!out_valid) begin
            chk(out_data == '0, "R7", "idle data", out_data, 0);
        end
        vh1 = vh0;
        vh0 = v;
        in_valid = v;
        in_a = a;
        in_b = b;
        if (v) begin
            q_data.push_back(PW'(a) * PW'(b));
            q_tag.push_back(cyc);
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: idle under reset
        repeat (3) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
            chk(out_data == '0, "R7", "data in reset", out_data, 0);
        end
        rst_n = 1'b1;

        // Dense sweep of every operand pair: R2, R3/R4/R5 alternation, R8 rate, R10 corners
        nvalid = 0;
        for (int i = 0; i < N * N; i++) begin
            step(1'b1, W'(i / N), W'(i % N), "R2/R3/R4/R5/R10");
        end
        step(1'b0, '0, '0, "R2");
        step(1'b0, '0, '0, "R2");
        chk(nvalid == N * N, "R8", "results at full rate", nvalid, N * N);

        // Every other cycle: all items land on one copy (R3)
        for (int i = 0; i < 2 * N; i++) begin
            step(i % 2 == 1, W'(N - 1 - (i % N)), W'(i % N), "R3");
        end
        // Two of three cycles busy (R6 bubbles)
        for (int i = 0; i < 3 * N; i++) begin
            step(i % 3 != 2, W'(i), W'(N - 1), "R6");
        end
        // One in four, maximum operands (R10)
        for (int i = 0; i < 4 * N; i++) begin
            step(i % 4 == 0, W'(N - 1), W'(N - 1 - (i % 2)), "R10");
        end
        step(1'b0, '0, '0, "R2");
        step(1'b0, '0, '0, "R2");

        // Reset with items in flight (R1)
        step(1'b1, W'(3), W'(5), "R2");
        step(1'b1, W'(7), W'(9), "R2");
        rst_n = 1'b0;
        in_valid = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R1", "valid after async reset", out_valid, 0);
        q_data.delete();
        q_tag.delete();
        vh0 = 1'b0;
        vh1 = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(out_valid == 1'b0, "R1", "valid first cycle after release", out_valid, 0);

        // Restart after reset: short dense burst then drain (R2, R9)
        for (int i = 0; i < N; i++) begin
            step(1'b1, W'(i), W'(i), "R2");
        end
        for (int i = 0; i < 3; i++) begin
            step(1'b0, '0, '0, "R2");
        end
        chk(q_data.size() == 0, "R9", "items left in queue", q_data.size(), 0);

        summary();
        $finish;
    end
endmodule